// File: doc/BRIEF.md
# Shared-Prescaler Timer/Counter

This block holds an 8-bit count register that a host reads and writes. The register advances from one of two sources. In timer mode the source is the instruction-cycle tick: each clock edge where `cyc_en` is high is one instruction cycle. In counter mode the source is a chosen edge of a raw external pin, sampled on instruction cycles. An 8-bit prescaler can sit between the source and the register and divide the source by a power of two. It can instead be handed to a watchdog tick path. It never serves both at once. The prescaler count is hidden from the host.

Source events are not applied to the register at once. A prescaler output passes through a two-stage synchronizing pipe before the register moves. After any host write, a small gate state machine blocks incrementing for two instruction cycles. The gate has three states. `GATE_OPEN` allows increments. A write in any state moves it to `GATE_HOLD_A`. From there, the next instruction cycle moves it to `GATE_HOLD_B`, and the one after that moves it back to `GATE_OPEN`. An increment that carries the register from 0xFF to 0x00 raises a one-clock overflow pulse.

When the prescaler is on the watchdog path, it counts instruction cycles. It then emits a one-clock `wdt_tick` pulse once per full division period.

Top module: `tmr_shared_pre`

## Requirements
- R1: After reset, `rd_data` is 0x00, `ovf_pulse` is 0, `wdt_tick` is 0, the internal prescaler count is zero and the gate is in `GATE_OPEN`.
- R2: A clock edge with `wr_en` high loads `wr_data` into the register, whatever the state of `cyc_en`. The new value shows on `rd_data` after that edge. A write takes priority over an increment at the same edge.
- R3: The two instruction cycles after a write never increment the register. In timer mode at 1:1, the value written is read after the write edge and after the next two instruction edges. The value plus one is read after the third.
- R4: In timer mode (`cfg_src_pin`=0) with the prescaler on the watchdog (`cfg_pre_to_wdt`=1), the register gains one per instruction cycle. A tick reaches the register two instruction edges after the cycle it belongs to. Edges with `cyc_en` low change neither the register nor any pipeline stage.
- R5: In counter mode (`cfg_src_pin`=1) with `cfg_fall_edge`=0, each rising edge of `ext_pin` adds one. The pin is sampled on instruction edges. The register moves on the third instruction edge after the edge that first samples the pin high.
- R6: With `cfg_fall_edge`=1, falling edges of `ext_pin` are counted instead, with the same latency.
- R7: With `cfg_pre_to_wdt`=0, the register advances once per 2^(`cfg_rate`+1) source events. Code 0 gives 1:2, code 2 gives 1:8 and code 7 gives 1:256.
- R8: A write while `cfg_pre_to_wdt`=0 clears the prescaler count. In timer mode at 1:8, the first increment after a write lands on the tenth instruction edge after the write edge.
- R9: With `cfg_pre_to_wdt`=1, `wdt_tick` pulses for one clock once every 2^(`cfg_rate`+1) instruction cycles. With `cfg_pre_to_wdt`=0 it stays low. Any change of `cfg_pre_to_wdt` clears the prescaler count.
- R10: `ovf_pulse` is high for exactly one clock, after the edge where an increment takes the register from 0xFF to 0x00. Loading 0x00 by a write never raises it.
- R11: `rd_data` always shows the current register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | High on clock edges that are instruction cycles |
| cfg_src_pin | input | 1 | 0 = count instruction cycles, 1 = count pin edges |
| cfg_fall_edge | input | 1 | Counter mode edge: 0 = rising, 1 = falling |
| cfg_pre_to_wdt | input | 1 | 0 = prescaler ahead of the register, 1 = prescaler on the watchdog path |
| cfg_rate | input | 3 | Division code n, ratio 2^(n+1) |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write value |
| rd_data | output | 8 | Current register value |
| ext_pin | input | 1 | Raw external clock pin |
| ovf_pulse | output | 1 | One-clock pulse on 0xFF to 0x00 wrap |
| wdt_tick | output | 1 | Prescaled tick for the watchdog path |

## Verification
A behavioural model in the bench carries the delays from R3 to R5. Its pipeline stages and pin history are plain integers that move only on instruction edges. Register writes take effect one edge after the strobe. Source events appear on `rd_data` two instruction edges after their cycle, and pin edges one edge later than that. `ovf_pulse` and `wdt_tick` are valid after the edge that causes them. The bench drives inputs at falling clock edges and compares every output against the model at each falling edge, so every result is checked in the exact cycle it is due. Hand-computed checks confirm the write hold-off sequence, the 1:8 restart after a write, and the division ratios measured over whole periods.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    // Increment gate after a host write
    typedef enum logic [1:0] {
        GATE_OPEN   = 2'd0,
        GATE_HOLD_A = 2'd1,
        GATE_HOLD_B = 2'd2
    } gate_t;

    // Static configuration word
    typedef struct packed {
        logic src_pin;
        logic fall_edge;
        logic pre_to_wdt;
    } ctl_t;

endpackage

// File: rtl/tsp_pin_edge.sv
module tsp_pin_edge #(
    parameter int PIN_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic ext_pin,
    input  logic src_pin,
    input  logic fall_edge,
    output logic src_ev
);
    logic [PIN_STAGES-1:0] pin_sh;
    logic newer, older, rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_sh <= '0;
        end else if (cyc_en) begin
            pin_sh <= {pin_sh[PIN_STAGES-2:0], ext_pin};
        end
    end

    always_comb begin
        newer = pin_sh[PIN_STAGES-2];
        older = pin_sh[PIN_STAGES-1];
        rise  = newer & ~older;
        fall  = ~newer & older;
        if (src_pin) begin
            src_ev = fall_edge ? fall : rise;
        end else begin
            src_ev = 1'b1;
        end
    end

    // R5
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> $stable(pin_sh));

endmodule

// File: rtl/tsp_prescale.sv
module tsp_prescale #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              src_ev,
    input  logic              pre_to_wdt,
    input  logic [RATE_W-1:0] rate,
    input  logic              wr_en,
    output logic              cnt_ev,
    output logic              wdt_tick
);
    localparam int PRE_W = 1 << RATE_W;
    localparam logic [PRE_W-1:0] ALL_ONE = '1;

    logic [PRE_W-1:0] pre_q, pre_d, term;
    logic             asg_q, chg, tick_in, at_term, adv, clr;

    always_comb begin
        term    = ALL_ONE >> (~rate);
        chg     = (pre_to_wdt != asg_q);
        tick_in = pre_to_wdt ? 1'b1 : src_ev;
        at_term = (pre_q >= term);
        adv     = cyc_en && tick_in && !chg;
        clr     = chg || (wr_en && !pre_to_wdt);
        if (clr) begin
            pre_d = '0;
        end else if (adv) begin
            pre_d = at_term ? '0 : pre_q + PRE_W'(1);
        end else begin
            pre_d = pre_q;
        end
        if (pre_to_wdt) begin
            cnt_ev = src_ev;
        end else begin
            cnt_ev = src_ev && at_term && !chg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q    <= '0;
            asg_q    <= 1'b1;
            wdt_tick <= 1'b0;
        end else begin
            pre_q    <= pre_d;
            asg_q    <= pre_to_wdt;
            wdt_tick <= cyc_en && pre_to_wdt && !chg && at_term;
        end
    end

    // R9
    wdt_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tick |-> $past(pre_to_wdt));

    // R9
    assign_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_to_wdt != asg_q) |=> (pre_q == '0));

endmodule

// File: rtl/tsp_count_core.sv
module tsp_count_core
    import tsp_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             cnt_ev,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_pulse
);
    logic [SYNC_STAGES-1:0] sp;
    logic                   sync_out, gate_open, inc, wrap;
    gate_t                  st, st_nx;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      sp <= '0;
                else if (cyc_en) sp <= cnt_ev;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      sp <= '0;
                else if (cyc_en) sp <= {sp[SYNC_STAGES-2:0], cnt_ev};
            end
        end
    endgenerate

    assign sync_out = sp[SYNC_STAGES-1];

    // Gate state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= GATE_OPEN;
        else        st <= st_nx;
    end

    // Gate next state
    always_comb begin
        st_nx = st;
        if (wr_en) begin
            st_nx = GATE_HOLD_A;
        end else if (cyc_en) begin
            unique case (st)
                GATE_OPEN:   st_nx = GATE_OPEN;
                GATE_HOLD_A: st_nx = GATE_HOLD_B;
                GATE_HOLD_B: st_nx = GATE_OPEN;
                default:     st_nx = GATE_OPEN;
            endcase
        end
    end

    // Gate outputs
    always_comb begin
        unique case (st)
            GATE_OPEN:   gate_open = 1'b1;
            GATE_HOLD_A: gate_open = 1'b0;
            GATE_HOLD_B: gate_open = 1'b0;
            default:     gate_open = 1'b0;
        endcase
        inc  = cyc_en && sync_out && gate_open && !wr_en;
        wrap = inc && (cnt_q == '1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            ovf_pulse <= 1'b0;
        end else begin
            if (wr_en)    cnt_q <= wr_data;
            else if (inc) cnt_q <= cnt_q + CNT_W'(1);
            ovf_pulse <= wrap;
        end
    end

    // R2
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == $past(wr_data)));

    // R3
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != GATE_OPEN && !wr_en) |=> (cnt_q == $past(cnt_q)));

    // R4
    idle_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !wr_en) |=> $stable(cnt_q));

    // R10
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (cnt_q == '0 && $past(cnt_q) == '1));

    // R10
    ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse);

endmodule

// File: rtl/tmr_shared_pre.sv
module tmr_shared_pre
    import tsp_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int RATE_W      = 3,
    parameter int PIN_STAGES  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              cfg_src_pin,
    input  logic              cfg_fall_edge,
    input  logic              cfg_pre_to_wdt,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              ext_pin,
    output logic              ovf_pulse,
    output logic              wdt_tick
);
    ctl_t ctl;
    logic src_ev, cnt_ev;

    assign ctl = '{src_pin: cfg_src_pin, fall_edge: cfg_fall_edge,
                   pre_to_wdt: cfg_pre_to_wdt};

    tsp_pin_edge #(.PIN_STAGES(PIN_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .src_pin(ctl.src_pin), .fall_edge(ctl.fall_edge), .src_ev(src_ev)
    );

    tsp_prescale #(.RATE_W(RATE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .src_ev(src_ev),
        .pre_to_wdt(ctl.pre_to_wdt), .rate(cfg_rate), .wr_en(wr_en),
        .cnt_ev(cnt_ev), .wdt_tick(wdt_tick)
    );

    tsp_count_core #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .cnt_ev(cnt_ev),
        .wr_en(wr_en), .wr_data(wr_data), .cnt_q(rd_data),
        .ovf_pulse(ovf_pulse)
    );

endmodule

// File: tb/sim_tmr_shared_pre.sv
`timescale 1ns/1ps
module sim_tmr_shared_pre;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b1;
    logic       cfg_src_pin = 1'b0, cfg_fall_edge = 1'b0, cfg_pre_to_wdt = 1'b1;
    logic [2:0] cfg_rate = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ext_pin = 1'b0;
    logic       ovf_pulse, wdt_tick;

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    tmr_shared_pre u0 (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .cfg_src_pin(cfg_src_pin),
        .cfg_fall_edge(cfg_fall_edge), .cfg_pre_to_wdt(cfg_pre_to_wdt),
        .cfg_rate(cfg_rate), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ext_pin(ext_pin), .ovf_pulse(ovf_pulse),
        .wdt_tick(wdt_tick)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_cnt, m_pre, m_hold, m_term;
    int m_asgq, m_ph1, m_ph2, m_s1, m_s2, m_ovf, m_wdt;
    int t_chg, t_ev, t_wrap, t_p, t_inc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_hold = 0; m_asgq = 1;
            m_ph1 = 0; m_ph2 = 0; m_s1 = 0; m_s2 = 0; m_ovf = 0; m_wdt = 0;
        end else begin
            m_term = (1 << (int'(cfg_rate) + 1)) - 1;
            t_chg  = (int'(cfg_pre_to_wdt) != m_asgq);
            if (!cfg_src_pin)       t_ev = 1;
            else if (!cfg_fall_edge) t_ev = (m_ph1 == 1 && m_ph2 == 0);
            else                     t_ev = (m_ph1 == 0 && m_ph2 == 1);
            t_wrap = (m_pre >= m_term);
            t_p    = cfg_pre_to_wdt ? t_ev : (t_ev && t_wrap && !t_chg);
            t_inc  = cyc_en && m_s2 && (m_hold == 0) && !wr_en;
            m_ovf  = t_inc && (m_cnt == 255);
            m_wdt  = cyc_en && cfg_pre_to_wdt && !t_chg && t_wrap;
            if (t_chg || (wr_en && !cfg_pre_to_wdt)) m_pre = 0;
            else if (cyc_en && (cfg_pre_to_wdt || t_ev)) m_pre = t_wrap ? 0 : m_pre + 1;
            if (wr_en)      m_cnt = int'(wr_data);
            else if (t_inc) m_cnt = (m_cnt + 1) % 256;
            if (wr_en) m_hold = 2;
            else if (cyc_en && m_hold > 0) m_hold = m_hold - 1;
            if (cyc_en) begin
                m_s2 = m_s1; m_s1 = t_p; m_ph2 = m_ph1; m_ph1 = int'(ext_pin);
            end
            m_asgq = int'(cfg_pre_to_wdt);
        end
    end

    // R11: cycle-by-cycle comparison
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cur_req, "rd_data", int'(rd_data), m_cnt);
            chk(cur_req, "ovf_pulse", int'(ovf_pulse), m_ovf);
            chk(cur_req, "wdt_tick", int'(wdt_tick), m_wdt);
        end
    end

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin = 1'b1; repeat (3) @(negedge clk);
            ext_pin = 1'b0; repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        int a, s;
        repeat (3) @(negedge clk);
        chk("R1", "rd_data", int'(rd_data), 0);
        chk("R1", "ovf_pulse", int'(ovf_pulse), 0);
        chk("R1", "wdt_tick", int'(wdt_tick), 0);
        rst_n = 1'b1; cmp_on = 1;

        cur_req = "R4";
        repeat (20) @(negedge clk);
        a = int'(rd_data); repeat (10) @(negedge clk);
        chk("R4", "timer delta", (int'(rd_data) - a) & 255, 10);
        for (int i = 0; i < 30; i++) begin @(negedge clk); cyc_en = (i % 3) != 0; end
        @(negedge clk); cyc_en = 1'b0; a = int'(rd_data);
        repeat (5) @(negedge clk);
        chk("R4", "idle hold", int'(rd_data), a);
        cyc_en = 1'b1;

        cur_req = "R3";
        repeat (5) @(negedge clk);
        wr(8'h10);
        chk("R2", "write load", int'(rd_data), 16);
        @(negedge clk); chk("R3", "hold 1", int'(rd_data), 16);
        @(negedge clk); chk("R3", "hold 2", int'(rd_data), 16);
        @(negedge clk); chk("R3", "resume", int'(rd_data), 17);
        @(negedge clk); cyc_en = 1'b0;
        cur_req = "R2";
        wr(8'h5A);
        chk("R2", "write while idle", int'(rd_data), 90);
        cyc_en = 1'b1;

        cur_req = "R10";
        repeat (5) @(negedge clk);
        wr(8'hFD); s = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); s += int'(ovf_pulse); end
        chk("R10", "ovf count", s, 1);
        wr(8'hFF); wr(8'h00);
        chk("R10", "write zero value", int'(rd_data), 0);
        chk("R10", "no ovf on write", int'(ovf_pulse), 0);
        repeat (4) @(negedge clk);

        cur_req = "R9";
        cfg_rate = 3'd1; repeat (10) @(negedge clk); s = 0;
        for (int i = 0; i < 64; i++) begin @(negedge clk); s += int'(wdt_tick); end
        chk("R9", "wdt 1:4 count", s, 16);
        cfg_rate = 3'd0; repeat (6) @(negedge clk); s = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); s += int'(wdt_tick); end
        chk("R9", "wdt 1:2 count", s, 10);
        cfg_pre_to_wdt = 1'b0; s = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); s += int'(wdt_tick); end
        chk("R9", "wdt quiet", s, 0);

        cur_req = "R7";
        repeat (10) @(negedge clk); a = int'(rd_data);
        repeat (40) @(negedge clk);
        chk("R7", "1:2 delta", (int'(rd_data) - a) & 255, 20);
        cfg_rate = 3'd7; repeat (10) @(negedge clk); a = int'(rd_data);
        repeat (512) @(negedge clk);
        chk("R7", "1:256 delta", (int'(rd_data) - a) & 255, 2);
        cfg_rate = 3'd2; repeat (20) @(negedge clk); a = int'(rd_data);
        repeat (64) @(negedge clk);
        chk("R7", "1:8 delta", (int'(rd_data) - a) & 255, 8);

        cur_req = "R8";
        repeat (3) @(negedge clk);
        wr(8'h40);
        repeat (9) @(negedge clk);
        chk("R8", "before first tick", int'(rd_data), 64);
        @(negedge clk);
        chk("R8", "first tick", int'(rd_data), 65);

        cur_req = "R5";
        cfg_pre_to_wdt = 1'b1; cfg_src_pin = 1'b1; cfg_fall_edge = 1'b0;
        repeat (8) @(negedge clk); a = int'(rd_data);
        pulses(10); repeat (6) @(negedge clk);
        chk("R5", "rising count", (int'(rd_data) - a) & 255, 10);

        cur_req = "R6";
        cfg_fall_edge = 1'b1;
        repeat (8) @(negedge clk); a = int'(rd_data);
        pulses(10); repeat (6) @(negedge clk);
        chk("R6", "falling count", (int'(rd_data) - a) & 255, 10);

        cur_req = "R7";
        cfg_fall_edge = 1'b0; cfg_pre_to_wdt = 1'b0; cfg_rate = 3'd1;
        repeat (8) @(negedge clk); a = int'(rd_data);
        pulses(12); repeat (6) @(negedge clk);
        chk("R7", "pin 1:4 count", (int'(rd_data) - a) & 255, 3);

        cur_req = "R11";
        repeat (10) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL %s watchdog actual=timeout expected=finish", cur_req);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule